// File: doc/BRIEF.md
# Display controller command interface

This block sits behind the byte receiver of a small greyscale display controller. Each accepted byte comes with a select level that marks it as pixel data or as command traffic. Pixel data bytes are forwarded on a data strobe to the address generator and RAM write port, which live elsewhere. Command bytes go into a collector. The collector takes the first byte as an opcode, looks up how many operand bytes that opcode needs and gathers them. When the last operand arrives, the command is complete.

Completed commands update the controller's addressing registers: the column window, the row window with their current pointers, and an 8-bit remap register whose bit 2 selects vertical address increment. The analogue setup commands (contrast, current, timing, grey scale and similar) still consume their operand bytes so that the byte stream stays aligned, but they change nothing. An opcode the block does not know raises a one-cycle error pulse. Every committed window or remap update raises a one-cycle update strobe.

Top module: `disp_cmd_if`

## Requirements
- R1: After reset the column window is start 0, end 63, pointer 0. The row window is start 0, end 79, pointer 0. Remap is 0x00, vert_inc is 0, and reg_upd and cmd_err are low.
- R2: A byte with byte_vld=1 and dc_is_data=1 appears in the same cycle on pix_vld=1 and pix_byte. It changes no register, and it does not advance or clear the command collector.
- R3: Opcode 0x15 takes two operands. At the clock edge that accepts the second operand, col_start and col_ptr become operand1 mod 64 and col_end becomes operand2 mod 64.
- R4: Opcode 0x75 takes two operands. At the edge that accepts the second operand, row_start and row_ptr become operand1 mod 80 and row_end becomes operand2 mod 80.
- R5: Opcode 0xA0 takes one operand and stores it in remap. vert_inc equals remap bit 2.
- R6: Operand counts are as follows. 0xB8 takes eight. 0x81, 0xA1, 0xA2, 0xA8, 0xAD, 0xB1, 0xB2, 0xB3, 0xBC, 0xBE and 0xBF take one each. 0x84 to 0x86, 0xA4 to 0xA7, 0xAE, 0xAF and 0xE3 take none. Operand bytes are never decoded as opcodes. After a command completes, the next command byte is an opcode.
- R7: The command byte 0xFF in opcode position is discarded. It raises neither cmd_err nor reg_upd, and the next command byte is an opcode.
- R8: Any other unlisted byte in opcode position drives cmd_err high for exactly one cycle, starting the cycle after it is accepted. It changes no register, and the next command byte is an opcode. An unlisted value in operand position is not an error.
- R9: Data bytes that arrive between the operands of a command do not clear the partial command. Gathering resumes with the next command byte.
- R10: reg_upd is high for exactly one cycle after a 0x15, 0x75 or 0xA0 command completes. It stays low for every other command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_vld | input | 1 | A byte is offered this cycle |
| byte_in | input | 8 | Received byte |
| dc_is_data | input | 1 | 1: pixel data, 0: command or operand |
| pix_vld | output | 1 | Pixel data byte forwarded |
| pix_byte | output | 8 | Forwarded pixel data |
| col_start | output | 6 | Column window start |
| col_end | output | 6 | Column window end |
| col_ptr | output | 6 | Current column |
| row_start | output | 7 | Row window start |
| row_end | output | 7 | Row window end |
| row_ptr | output | 7 | Current row |
| remap | output | 8 | Remap register |
| vert_inc | output | 1 | Vertical increment selected (remap bit 2) |
| reg_upd | output | 1 | One-cycle strobe on window or remap commit |
| cmd_err | output | 1 | One-cycle strobe on unknown opcode |

## Verification
The assertions assume that byte_vld is a single-cycle offer. They also assume that dc_is_data and byte_in are settled while byte_vld is high, because every rule is keyed to the accepting edge. The stimulus drives all inputs half a cycle before that edge and drops byte_vld after one cycle, so each accepted byte is exactly one offer. The bench separates commands with idle cycles when it checks that a strobe falls. It also mixes data bytes, unlisted values and 0xFF into operand positions, so that operand counting, rather than byte values, decides what is decoded as an opcode.

// File: rtl/disp_cmd_pkg.sv
package disp_cmd_pkg;

    localparam logic [7:0] OP_COL_WIN = 8'h15;
    localparam logic [7:0] OP_ROW_WIN = 8'h75;
    localparam logic [7:0] OP_REMAP   = 8'hA0;
    localparam logic [7:0] OP_GREY    = 8'hB8;
    localparam logic [7:0] OP_DISCARD = 8'hFF;

    // Largest operand count any opcode needs
    localparam int LONGEST_CMD = 8;

    typedef struct packed {
        logic       known;
        logic       discard;
        logic [3:0] nargs;
    } op_info_t;

    function automatic op_info_t lookup_op(input logic [7:0] op);
        op_info_t r;
        r = '{known: 1'b1, discard: 1'b0, nargs: 4'd0};
        case (op)
            OP_COL_WIN, OP_ROW_WIN:                 r.nargs = 4'd2;
            8'h81, OP_REMAP, 8'hA1, 8'hA2, 8'hA8, 8'hAD,
            8'hB1, 8'hB2, 8'hB3, 8'hBC, 8'hBE, 8'hBF: r.nargs = 4'd1;
            OP_GREY:                                r.nargs = 4'd8;
            8'h84, 8'h85, 8'h86, 8'hA4, 8'hA5, 8'hA6,
            8'hA7, 8'hAE, 8'hAF, 8'hE3:             r.nargs = 4'd0;
            OP_DISCARD:                             r.discard = 1'b1;
            default:                                r.known = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/disp_cmd_decode.sv
module disp_cmd_decode
    import disp_cmd_pkg::*;
(
    input  logic [7:0] op,
    output op_info_t   info
);
    always_comb begin
        info = lookup_op(op);
    end
endmodule

// File: rtl/disp_cmd_collect.sv
module disp_cmd_collect
    import disp_cmd_pkg::*;
#(
    parameter int MAX_ARGS = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       byte_vld,
    input  logic [7:0] byte_in,
    input  logic       dc_is_data,
    output logic       cmd_done,
    output logic [7:0] done_op,
    output logic [7:0] done_arg0,
    output logic [7:0] done_arg1,
    output logic       err_q
);
    localparam int CNT_W = $clog2(MAX_ARGS + 1);

    typedef struct packed {
        logic [CNT_W-1:0]              cnt;
        logic [7:0]                    op;
        logic [MAX_ARGS-1:0][7:0]      args;
        logic                          err;
    } col_state_t;

    col_state_t st_d, st_q;
    op_info_t   info;
    logic [7:0] dec_op;
    logic       cmd_byte;

    initial begin
        if (MAX_ARGS < LONGEST_CMD) $error("MAX_ARGS below longest command");
    end

    assign cmd_byte = byte_vld && !dc_is_data;
    assign dec_op   = (st_q.cnt == '0) ? byte_in : st_q.op;

    disp_cmd_decode u_dec (
        .op   (dec_op),
        .info (info)
    );

    always_comb begin
        st_d     = st_q;
        st_d.err = 1'b0;
        cmd_done = 1'b0;
        if (cmd_byte) begin
            if (st_q.cnt == '0) begin
                if (info.discard) begin
                    st_d.cnt = '0;
                end else if (!info.known) begin
                    st_d.err = 1'b1;
                    st_d.cnt = '0;
                end else if (info.nargs == 4'd0) begin
                    cmd_done = 1'b1;
                end else begin
                    st_d.op  = byte_in;
                    st_d.cnt = CNT_W'(1);
                end
            end else begin
                if (st_q.cnt <= CNT_W'(MAX_ARGS))
                    st_d.args[st_q.cnt - CNT_W'(1)] = byte_in;
                if (st_q.cnt == CNT_W'(info.nargs)) begin
                    cmd_done = 1'b1;
                    st_d.cnt = '0;
                end else begin
                    st_d.cnt = st_q.cnt + CNT_W'(1);
                end
            end
        end
        done_op   = dec_op;
        done_arg0 = st_d.args[0];
        done_arg1 = st_d.args[1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign err_q = st_q.err;

    logic [CNT_W-1:0] cnt_q;
    assign cnt_q = st_q.cnt;

    // R6: operand counter never exceeds buffer depth
    a_r6_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(MAX_ARGS));

    // R2, R9: data bytes leave the partial command untouched
    a_r9_data_keeps_cnt: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && dc_is_data) |=> $stable(cnt_q));

    // R8: error pulse only follows an accepted command byte
    a_r8_err_source: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |-> $past(byte_vld && !dc_is_data));

    // R8: an error leaves the collector at opcode position
    a_r8_err_resets: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |-> (cnt_q == '0));
endmodule

// File: rtl/disp_cmd_regs.sv
module disp_cmd_regs
    import disp_cmd_pkg::*;
#(
    parameter int NUM_COLS = 64,
    parameter int NUM_ROWS = 80
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cmd_done,
    input  logic [7:0]                  done_op,
    input  logic [7:0]                  done_arg0,
    input  logic [7:0]                  done_arg1,
    output logic [$clog2(NUM_COLS)-1:0] col_start,
    output logic [$clog2(NUM_COLS)-1:0] col_end,
    output logic [$clog2(NUM_COLS)-1:0] col_ptr,
    output logic [$clog2(NUM_ROWS)-1:0] row_start,
    output logic [$clog2(NUM_ROWS)-1:0] row_end,
    output logic [$clog2(NUM_ROWS)-1:0] row_ptr,
    output logic [7:0]                  remap,
    output logic                        reg_upd
);
    localparam int COL_AW = $clog2(NUM_COLS);
    localparam int ROW_AW = $clog2(NUM_ROWS);

    typedef struct packed {
        logic [COL_AW-1:0] col_start;
        logic [COL_AW-1:0] col_end;
        logic [COL_AW-1:0] col_ptr;
        logic [ROW_AW-1:0] row_start;
        logic [ROW_AW-1:0] row_end;
        logic [ROW_AW-1:0] row_ptr;
        logic [7:0]        remap;
        logic              upd;
    } reg_state_t;

    reg_state_t rg_d, rg_q;

    always_comb begin
        rg_d     = rg_q;
        rg_d.upd = 1'b0;
        if (cmd_done) begin
            case (done_op)
                OP_COL_WIN: begin
                    rg_d.col_start = COL_AW'(32'(done_arg0) % NUM_COLS);
                    rg_d.col_ptr   = COL_AW'(32'(done_arg0) % NUM_COLS);
                    rg_d.col_end   = COL_AW'(32'(done_arg1) % NUM_COLS);
                    rg_d.upd       = 1'b1;
                end
                OP_ROW_WIN: begin
                    rg_d.row_start = ROW_AW'(32'(done_arg0) % NUM_ROWS);
                    rg_d.row_ptr   = ROW_AW'(32'(done_arg0) % NUM_ROWS);
                    rg_d.row_end   = ROW_AW'(32'(done_arg1) % NUM_ROWS);
                    rg_d.upd       = 1'b1;
                end
                OP_REMAP: begin
                    rg_d.remap = done_arg0;
                    rg_d.upd   = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rg_q           <= '0;
            rg_q.col_end   <= COL_AW'(NUM_COLS - 1);
            rg_q.row_end   <= ROW_AW'(NUM_ROWS - 1);
        end else begin
            rg_q <= rg_d;
        end
    end

    assign col_start = rg_q.col_start;
    assign col_end   = rg_q.col_end;
    assign col_ptr   = rg_q.col_ptr;
    assign row_start = rg_q.row_start;
    assign row_end   = rg_q.row_end;
    assign row_ptr   = rg_q.row_ptr;
    assign remap     = rg_q.remap;
    assign reg_upd   = rg_q.upd;

    // R3: column fields stay inside the column space
    a_r3_col_range: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(col_start) < NUM_COLS) && (32'(col_end) < NUM_COLS) && (32'(col_ptr) < NUM_COLS));

    // R4: row fields stay inside the row space
    a_r4_row_range: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(row_start) < NUM_ROWS) && (32'(row_end) < NUM_ROWS) && (32'(row_ptr) < NUM_ROWS));

    // R10: update strobe only after a completed command
    a_r10_upd_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        reg_upd |-> $past(cmd_done));

    // R2: registers hold while no command completes
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_done |=> ($stable(col_start) && $stable(col_end) && $stable(row_start)
                       && $stable(row_end) && $stable(remap)));
endmodule

// File: rtl/disp_cmd_if.sv
module disp_cmd_if
    import disp_cmd_pkg::*;
#(
    parameter int NUM_COLS = 64,
    parameter int NUM_ROWS = 80,
    parameter int MAX_ARGS = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        byte_vld,
    input  logic [7:0]                  byte_in,
    input  logic                        dc_is_data,
    output logic                        pix_vld,
    output logic [7:0]                  pix_byte,
    output logic [$clog2(NUM_COLS)-1:0] col_start,
    output logic [$clog2(NUM_COLS)-1:0] col_end,
    output logic [$clog2(NUM_COLS)-1:0] col_ptr,
    output logic [$clog2(NUM_ROWS)-1:0] row_start,
    output logic [$clog2(NUM_ROWS)-1:0] row_end,
    output logic [$clog2(NUM_ROWS)-1:0] row_ptr,
    output logic [7:0]                  remap,
    output logic                        vert_inc,
    output logic                        reg_upd,
    output logic                        cmd_err
);
    logic       cmd_done;
    logic [7:0] done_op;
    logic [7:0] done_arg0;
    logic [7:0] done_arg1;

    assign pix_vld  = byte_vld && dc_is_data;
    assign pix_byte = byte_in;

    disp_cmd_collect #(.MAX_ARGS(MAX_ARGS)) u_collect (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_vld   (byte_vld),
        .byte_in    (byte_in),
        .dc_is_data (dc_is_data),
        .cmd_done   (cmd_done),
        .done_op    (done_op),
        .done_arg0  (done_arg0),
        .done_arg1  (done_arg1),
        .err_q      (cmd_err)
    );

    disp_cmd_regs #(.NUM_COLS(NUM_COLS), .NUM_ROWS(NUM_ROWS)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_done  (cmd_done),
        .done_op   (done_op),
        .done_arg0 (done_arg0),
        .done_arg1 (done_arg1),
        .col_start (col_start),
        .col_end   (col_end),
        .col_ptr   (col_ptr),
        .row_start (row_start),
        .row_end   (row_end),
        .row_ptr   (row_ptr),
        .remap     (remap),
        .reg_upd   (reg_upd)
    );

    assign vert_inc = remap[2];

    // R5: increment direction follows the stored remap bit
    a_r5_vert: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vert_inc) |-> $past(cmd_done && done_op == OP_REMAP));

    // R8: error and update never strobe together
    a_r8_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_err && reg_upd));
endmodule

// File: tb/disp_cmd_if_tb_top.sv
`timescale 1ns/1ps
module disp_cmd_if_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       byte_vld = 1'b0;
    logic [7:0] byte_in = 8'h00;
    logic       dc_is_data = 1'b0;
    logic       pix_vld;
    logic [7:0] pix_byte;
    logic [5:0] col_start, col_end, col_ptr;
    logic [6:0] row_start, row_end, row_ptr;
    logic [7:0] remap;
    logic       vert_inc, reg_upd, cmd_err;

    int checks = 0;
    int failures = 0;
    logic       pv_s;
    logic [7:0] pb_s;

    always #4 clk = ~clk;

    disp_cmd_if dut_i (
        .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_in(byte_in),
        .dc_is_data(dc_is_data), .pix_vld(pix_vld), .pix_byte(pix_byte),
        .col_start(col_start), .col_end(col_end), .col_ptr(col_ptr),
        .row_start(row_start), .row_end(row_end), .row_ptr(row_ptr),
        .remap(remap), .vert_inc(vert_inc), .reg_upd(reg_upd), .cmd_err(cmd_err)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send(input logic dc, input logic [7:0] b);
        @(negedge clk);
        byte_vld   = 1'b1;
        dc_is_data = dc;
        byte_in    = b;
        #1;
        pv_s = pix_vld;
        pb_s = pix_byte;
        @(negedge clk);
        byte_vld   = 1'b0;
        dc_is_data = 1'b0;
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 col_start", col_start, 0);
        chk("R1 col_end", col_end, 63);
        chk("R1 col_ptr", col_ptr, 0);
        chk("R1 row_start", row_start, 0);
        chk("R1 row_end", row_end, 79);
        chk("R1 row_ptr", row_ptr, 0);
        chk("R1 remap", remap, 0);
        chk("R1 strobes", {reg_upd, cmd_err, vert_inc, pix_vld}, 0);
    endtask

    task automatic t_col();
        send(0, 8'h15); chk("R3 no upd mid", reg_upd, 0);
        send(0, 8'h45); chk("R3 unchanged mid", col_start, 0);
        send(0, 8'h7F);
        chk("R3 col_start mod", col_start, 5);
        chk("R3 col_ptr", col_ptr, 5);
        chk("R3 col_end mod", col_end, 63);
        chk("R10 upd col", reg_upd, 1);
        idle(); chk("R10 upd one cycle", reg_upd, 0);
        send(0, 8'h15); send(0, 8'h0A); send(0, 8'h14);
        chk("R3 col_start", col_start, 10);
        chk("R3 col_end", col_end, 20);
    endtask

    task automatic t_row();
        send(0, 8'h75); send(0, 8'h55); send(0, 8'hC8);
        chk("R4 row_start mod", row_start, 5);
        chk("R4 row_ptr", row_ptr, 5);
        chk("R4 row_end mod", row_end, 40);
        chk("R10 upd row", reg_upd, 1);
        send(0, 8'h75); send(0, 8'h4F); send(0, 8'h50);
        chk("R4 row_start 79", row_start, 79);
        chk("R4 row_end wraps", row_end, 0);
    endtask

    task automatic t_remap();
        send(0, 8'hA0); send(0, 8'h04);
        chk("R5 remap", remap, 4);
        chk("R5 vert_inc", vert_inc, 1);
        chk("R10 upd remap", reg_upd, 1);
        send(0, 8'hA0); send(0, 8'hFB);
        chk("R5 remap2", remap, 251);
        chk("R5 vert_inc off", vert_inc, 0);
    endtask

    task automatic t_data();
        send(1, 8'h5A);
        chk("R2 pix_vld", pv_s, 1);
        chk("R2 pix_byte", pb_s, 8'h5A);
        chk("R2 col unchanged", col_start, 10);
        chk("R2 no upd", reg_upd, 0);
        send(1, 8'h15); send(1, 8'h01); send(1, 8'h02);
        chk("R2 data not cmd", col_start, 10);
        send(0, 8'hE3);
        chk("R2 cmd pix_vld low", pv_s, 0);
        chk("R10 no upd E3", reg_upd, 0);
    endtask

    task automatic t_args();
        send(0, 8'h81); send(0, 8'h15);
        chk("R6 81 arg not opcode", col_start, 10);
        chk("R6 81 no err", cmd_err, 0);
        send(0, 8'hA4);
        chk("R10 no upd A4", reg_upd, 0);
        send(0, 8'h15); send(0, 8'h0B); send(0, 8'h0C);
        chk("R6 after zero-arg", col_start, 11);
        send(0, 8'hB8);
        for (int i = 0; i < 8; i++) begin
            send(0, 8'h15);
            chk("R6 B8 arg no err", cmd_err, 0);
        end
        chk("R6 B8 col held", col_start, 11);
        chk("R10 no upd B8", reg_upd, 0);
        send(0, 8'h15); send(0, 8'h1E); send(0, 8'h28);
        chk("R6 after B8 start", col_start, 30);
        chk("R6 after B8 end", col_end, 40);
        send(0, 8'hAD); send(0, 8'h00);
        chk("R8 unlisted operand no err", cmd_err, 0);
        send(0, 8'hA0); send(0, 8'h00);
        chk("R6 after AD", remap, 0);
    endtask

    task automatic t_discard();
        send(0, 8'hFF);
        chk("R7 no err", cmd_err, 0);
        chk("R7 no upd", reg_upd, 0);
        send(0, 8'h15); send(0, 8'h02); send(0, 8'h03);
        chk("R7 next is opcode", col_start, 2);
        send(0, 8'hA1); send(0, 8'hFF);
        chk("R7 FF operand", cmd_err, 0);
        send(0, 8'h15); send(0, 8'h04); send(0, 8'h05);
        chk("R7 after FF operand", col_start, 4);
    endtask

    task automatic t_unknown();
        send(0, 8'h00);
        chk("R8 err pulse", cmd_err, 1);
        chk("R8 col held", col_start, 4);
        chk("R8 no upd", reg_upd, 0);
        idle(); chk("R8 err one cycle", cmd_err, 0);
        send(0, 8'h15); send(0, 8'h01); send(0, 8'h02);
        chk("R8 next opcode", col_start, 1);
        chk("R8 no err on valid", cmd_err, 0);
        send(0, 8'h42); send(0, 8'h43);
        chk("R8 back to back err", cmd_err, 1);
    endtask

    task automatic t_resume();
        send(0, 8'h75); send(0, 8'h03);
        send(1, 8'h75); send(1, 8'h10);
        chk("R9 held mid", row_start, 79);
        send(0, 8'h09);
        chk("R9 row_start", row_start, 3);
        chk("R9 row_end", row_end, 9);
        chk("R9 upd", reg_upd, 1);
    endtask

    initial begin
        #(8 * 100000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle();
        t_reset();
        t_col();
        t_row();
        t_remap();
        t_data();
        t_args();
        t_discard();
        t_unknown();
        t_resume();
        idle();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule